// File: doc/BRIEF.md
# Time-Shared Long FIR Filter

This block produces one filtered value for every sample it accepts. It keeps the latest `TAPS` samples in a circular history. A single multiplier and adder pair walks every tap in turn, using coefficients from an on-chip table that software may rewrite while the filter runs.

An accepted sample starts one pass over all taps. When the pass ends, the wide sum is shifted left by a programmable amount and clamped if it no longer fits. The upper `OW` bits are then presented together with a one-cycle valid strobe.

Two sticky flags report trouble. One reports arithmetic wrap in the accumulator. The other reports a sample that arrived while a pass was still in progress.

`TAPS` must be a power of two. The defaults are 1024 taps, 18-bit samples and coefficients, a 44-bit accumulator, a 16-bit result and a shift limit of 28.

Top module: `fir_seq_mac`

## Requirements
- R1: Each result equals the sum over k = 0..TAPS-1 of coef[k] times the sample accepted k strobes earlier, where k = 0 is the sample just accepted. Samples and coefficients are AW-bit-extended two's complement, and each product is added modulo 2^AW.
- R2: Every accepted sample enters the history and pushes out the oldest one, so a sample older than TAPS strobes no longer contributes.
- R3: `res_valid` is high for exactly one cycle, on the TAPS+1-th rising edge after the edge that accepted the sample.
- R4: Before truncation, the final sum is shifted left by the shift setting. A shifted value above 2^(AW-1)-1 becomes that value, and one below -2^(AW-1) becomes that value.
- R5: `res_data` is bits AW-1 down to AW-OW of the shifted and clamped value.
- R6: The shift setting resets to 0 and is loaded by `shift_we`. A value greater than MAX_SHIFT is ignored and the previous setting is kept.
- R7: A coefficient write changes only results of passes accepted after the write cycle. A write during a running pass, or in the same cycle as an accepted sample, leaves that pass unchanged.
- R8: Reset empties the history to zeros, clears the accumulator and both flags, and keeps the coefficient table.
- R9: `ovf_err` becomes 1 when any addition in a pass leaves the signed AW-bit range. It stays 1 until reset.
- R10: A sample strobe that arrives while a pass or its final cycle is in progress is discarded and is never stored. It sets the sticky `overrun_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample strobe |
| smp_data | input | DW | Sample, two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | log2(TAPS) | Tap index being written |
| coef_data | input | CW | Coefficient, two's complement |
| shift_we | input | 1 | Shift setting write enable |
| shift_val | input | SHW | Requested left shift |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | OW | Upper bits of scaled sum |
| ovf_err | output | 1 | Sticky accumulator wrap flag |
| overrun_err | output | 1 | Sticky dropped-sample flag |

## Verification
The accumulator can only wrap once most of the history and most of the coefficients sit at full negative scale. At the default size, filling the history that way would take far more cycles than a run allows. The bench therefore instantiates a 64-tap, 40-bit-accumulator variant. It loads every coefficient with the most negative value and then streams more than 64 most-negative samples, so the wrap occurs partway through a pass. The other two mid-pass events, a coefficient rewrite and an overlapping strobe, are placed at fixed cycle offsets inside a running pass. The bench then compares against a model that ignores both events.

// File: rtl/fir_seq_mac.sv
module fir_seq_mac #(
  parameter int TAPS      = 1024,
  parameter int DW        = 18,
  parameter int CW        = 18,
  parameter int AW        = 44,
  parameter int OW        = 16,
  parameter int SHW       = 5,
  parameter int MAX_SHIFT = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [DW-1:0]            smp_data,
  input  logic                     coef_we,
  input  logic [$clog2(TAPS)-1:0]  coef_addr,
  input  logic [CW-1:0]            coef_data,
  input  logic                     shift_we,
  input  logic [SHW-1:0]           shift_val,
  output logic                     res_valid,
  output logic [OW-1:0]            res_data,
  output logic                     ovf_err,
  output logic                     overrun_err
);
  localparam int IW = $clog2(TAPS);
  localparam int PW = DW + CW;
  localparam int WW = AW + MAX_SHIFT;

  logic signed [DW-1:0] hist      [TAPS];
  logic signed [CW-1:0] coef_pend [TAPS];
  logic signed [CW-1:0] coef_live [TAPS];

  logic [IW-1:0]        wptr, base, idx;
  logic                 busy, fin;
  logic signed [AW-1:0] acc;
  logic [SHW-1:0]       sh_q;

  logic                 accept;
  logic [IW-1:0]        tap_sel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x, sum;
  logic                 add_ovf;
  logic [WW-1:0]        wide;
  logic                 fits;
  logic [AW-1:0]        clamp, scaled;

  assign accept  = smp_valid & ~busy & ~fin;
  assign tap_sel = base - idx;
  assign prod    = hist[tap_sel] * coef_live[idx];
  assign prod_x  = {{(AW-PW){prod[PW-1]}}, prod};
  assign sum     = acc + prod_x;
  assign add_ovf = (acc[AW-1] == prod_x[AW-1]) && (sum[AW-1] != acc[AW-1]);

  assign wide    = {{MAX_SHIFT{acc[AW-1]}}, acc} << sh_q;
  assign fits    = ~|wide[WW-1:AW-1] | &wide[WW-1:AW-1];
  assign clamp   = acc[AW-1] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
  assign scaled  = fits ? wide[AW-1:0] : clamp;

  always_ff @(posedge clk) begin
    if (coef_we) coef_pend[coef_addr] <= coef_data;
    if (accept)  coef_live <= coef_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist[k] <= '0;
      wptr        <= '0;
      base        <= '0;
      idx         <= '0;
      busy        <= 1'b0;
      fin         <= 1'b0;
      acc         <= '0;
      sh_q        <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      ovf_err     <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (shift_we && shift_val <= SHW'(MAX_SHIFT)) sh_q <= shift_val;
      if (smp_valid && (busy || fin)) overrun_err <= 1'b1;
      if (accept) begin
        hist[wptr] <= smp_data;
        base       <= wptr;
        wptr       <= wptr + 1'b1;
        idx        <= '0;
        acc        <= '0;
        busy       <= 1'b1;
      end else if (busy) begin
        acc <= sum;
        idx <= idx + 1'b1;
        if (add_ovf) ovf_err <= 1'b1;
        if (idx == IW'(TAPS-1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        fin       <= 1'b0;
        res_valid <= 1'b1;
        res_data  <= scaled[AW-1 -: OW];
      end
    end
  end
endmodule

// File: rtl/fir_seq_mac_chk.sv
module fir_seq_mac_chk #(
  parameter int TAPS      = 1024,
  parameter int SHW       = 5,
  parameter int MAX_SHIFT = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_valid,
  input logic           busy,
  input logic           fin,
  input logic           res_valid,
  input logic           ovf_err,
  input logic           overrun_err,
  input logic [SHW-1:0] sh_q
);
  logic [31:0] cnt;
  logic        pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (smp_valid && !busy && !fin) begin
      cnt  <= '0;
      pend <= 1'b1;
    end else if (res_valid) begin
      pend <= 1'b0;
    end else if (pend) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (pend && cnt == 32'(TAPS + 1)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> overrun_err);
  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(smp_valid && (busy || fin)));
  a_r6_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q <= SHW'(MAX_SHIFT));
  a_r10_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && fin));
endmodule

bind fir_seq_mac fir_seq_mac_chk #(.TAPS(TAPS), .SHW(SHW), .MAX_SHIFT(MAX_SHIFT)) u_chk (.*);

// File: tb/tb_fir_seq_mac.sv
module tb_fir_seq_mac;
  localparam int TAPS = 64;
  localparam int DW = 18, CW = 18, AW = 40, OW = 16, SHW = 5, MAXS = 28;
  localparam int IW = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic coef_we = 1'b0;
  logic [IW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic shift_we = 1'b0;
  logic [SHW-1:0] shift_val = '0;
  logic res_valid;
  logic [OW-1:0] res_data;
  logic ovf_err, overrun_err;

  int total = 0, bad = 0;
  longint mhist [TAPS];
  longint mpend [TAPS];
  longint mlive [TAPS];
  int msh = 0;
  bit movf = 0, movr = 0;

  always #2 clk = ~clk;

  fir_seq_mac #(.TAPS(TAPS), .DW(DW), .CW(CW), .AW(AW), .OW(OW), .SHW(SHW), .MAX_SHIFT(MAXS)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .shift_we(shift_we), .shift_val(shift_val), .res_valid(res_valid),
    .res_data(res_data), .ovf_err(ovf_err), .overrun_err(overrun_err));

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint r18();
    logic signed [17:0] t = 18'($urandom);
    return longint'(t);
  endfunction

  function automatic longint wrapa(longint v);
    return (v <<< (64 - AW)) >>> (64 - AW);
  endfunction

  function automatic logic [OW-1:0] model_out();
    longint acc = 0, s;
    longint maxa = (longint'(1) <<< (AW - 1)) - 1;
    longint mina = -(longint'(1) <<< (AW - 1));
    logic signed [127:0] w, e;
    for (int i = 0; i < TAPS; i++) begin
      s = acc + mhist[i] * mlive[i];
      if (s > maxa || s < mina) movf = 1;
      acc = wrapa(s);
    end
    w = 128'(acc);
    w = w <<< msh;
    if (w > 128'(maxa)) w = 128'(maxa);
    if (w < 128'(mina)) w = 128'(mina);
    e = w >>> (AW - OW);
    return e[OW-1:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < TAPS; i++) mhist[i] = 0;
    movf = 0; movr = 0; msh = 0;
    chk("R8 res_valid", res_valid, 0);
    chk("R8 ovf_err", ovf_err, 0);
    chk("R8 overrun_err", overrun_err, 0);
  endtask

  task automatic wr_coef(int a, longint v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = IW'(a); coef_data = CW'(v);
    mpend[a] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic wr_shift(int v);
    @(negedge clk);
    shift_we = 1'b1; shift_val = SHW'(v);
    if (v <= MAXS) msh = v;
    @(negedge clk);
    shift_we = 1'b0;
  endtask

  task automatic send(longint x, bit midwr, bit ovr, string tag);
    logic [OW-1:0] exp;
    int cnt = 0;
    bit got = 0;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = DW'(x);
    for (int i = TAPS - 1; i > 0; i--) mhist[i] = mhist[i-1];
    mhist[0] = x;
    mlive = mpend;
    exp = model_out();
    while (!got && cnt < TAPS + 50) begin
      @(negedge clk);
      cnt++;
      smp_valid = 1'b0;
      coef_we = 1'b0;
      if (res_valid) got = 1;
      else begin
        if (midwr && cnt == 10) begin
          longint v = r18();
          coef_we = 1'b1; coef_addr = '0; coef_data = CW'(v);
          mpend[0] = v;
        end
        if (ovr && cnt == 20) begin
          smp_valid = 1'b1; smp_data = DW'(r18());
          movr = 1;
        end
      end
    end
    chk({tag, " R3 latency"}, cnt, TAPS + 2);
    chk({tag, " data"}, longint'(res_data), longint'(exp));
    @(negedge clk);
    chk("R3 pulse width", res_valid, 0);
    chk("R9 ovf flag", ovf_err, movf);
    chk("R10 overrun flag", overrun_err, movr);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < TAPS; i++) begin mhist[i] = 0; mpend[i] = 0; mlive[i] = 0; end
    do_reset();

    for (int i = 0; i < TAPS; i++) wr_coef(i, i + 1);
    wr_shift(28);
    send(7, 0, 0, "R8 R1 first after reset");
    send(3, 0, 0, "R1 two taps");
    send(-200, 0, 0, "R1 negative");
    wr_shift(12);
    wr_shift(31);
    send(5000, 0, 0, "R6 invalid shift kept");
    chk("R6 model shift", msh, 12);
    wr_shift(0);
    send(131071, 0, 0, "R6 R5 zero shift");

    do_reset();
    for (int i = 0; i < TAPS; i++) wr_coef(i, 131071);
    wr_shift(28);
    send(131071, 0, 0, "R4 clamp positive");
    send(-131072, 0, 0, "R4 clamp negative");
    send(3, 0, 0, "R4 R5 in range");

    do_reset();
    for (int i = 0; i < TAPS; i++) wr_coef(i, r18());
    wr_shift(20);
    for (int k = 0; k < 150; k++) begin
      if (k % 3 == 0) wr_coef(int'($urandom % TAPS), r18());
      if (k % 11 == 0) wr_shift(int'($urandom % 32));
      send(r18(), k % 5 == 2, k % 7 == 3,
           (k % 5 == 2) ? "R7 mid-pass coef write" :
           (k % 7 == 3) ? "R10 dropped strobe" : "R1 R2 R4 R5 random");
    end

    do_reset();
    for (int i = 0; i < TAPS; i++) wr_coef(i, -131072);
    wr_shift(0);
    for (int k = 0; k < TAPS + 4; k++) send(-131072, 0, 0, "R9 wrap stress");
    chk("R9 flag raised", ovf_err, 1);

    do_reset();
    chk("R8 flags cleared ovf", ovf_err, 0);
    wr_shift(28);
    send(9, 0, 0, "R8 history cleared, coefs kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule